// File: doc/BRIEF.md
# Radix-3 Pipelined Maximum Finder

This block receives a set of unsigned words in parallel, qualified by a valid strobe, and reports the largest word of the set after exactly three clock cycles. The reduction is a tree of registered stages. Each stage splits its candidates into groups of up to three and keeps the largest of each group. With the default of eighteen words, the tree narrows the set to six candidates, then to two, then to one. A pairwise tree would need five stages for the same set.

A valid bit travels through the stages alongside the data. A new set may be presented on every cycle, so sets arriving every fourth cycle are well within reach. When a stage holds a group with fewer than three members, the group still works: a single survivor is registered unchanged and a pair is compared directly. Any word count from 2 to 27 therefore resolves in the same three stages. The data registers load only when the valid bit beside them is set, so the reported maximum holds still between results.

Top module: `tri_max_reduce`

## Requirements
- R1: While `rst_n` is low, and after its release until the first set has had time to pass through, `out_valid` is 0.
- R2: `out_valid` is 1 on exactly the cycles that follow, by three rising clock edges, a cycle with `in_valid` at 1. It is 0 on all other cycles.
- R3: When `out_valid` is 1, `out_max` equals the largest of the `N_IN` words captured three edges earlier. Word k occupies bits `[k*DATA_W +: DATA_W]` of `in_data`.
- R4: Words are compared as unsigned numbers, so a word with its top bit set ranks above every word whose top bit is clear.
- R5: When several words share the largest value, including the case where all words are equal, `out_max` equals that value. Internally, an equal comparison keeps the lower-indexed candidate.
- R6: Sets presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R7: On cycles where `out_valid` is 0, `out_max` keeps the last reported maximum. Data presented while `in_valid` is 0 has no effect on it.
- R8: When `N_IN` is not a multiple of three, a candidate left without a full group is carried forward unchanged. A maximum sitting in that position is still reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| in_valid | input | 1 | The set on `in_data` is to be reduced |
| in_data | input | N_IN*DATA_W | Flattened input words, word k at `[k*DATA_W +: DATA_W]` |
| out_valid | output | 1 | `out_max` carries a new result |
| out_max | output | DATA_W | Largest word of the set |

## Verification
The bench builds two copies of the block with `DATA_W` = 4. The first has the default `N_IN` of 18. The second has `N_IN` of 7, which leaves groups of one at the first and last stages. With only sixteen word values, the bench can place a single top value, or two equal top values, at every pair of positions. It also covers every uniform set and every top-bit crossing. Random valid patterns and data that changes on idle cycles exercise the result timing and the hold behaviour.

// File: rtl/tri_max_pkg.sv
package tri_max_pkg;

  // Number of groups of at most three needed to cover n candidates.
  function automatic int unsigned groups_of3(input int unsigned n);
    return (n + 2) / 3;
  endfunction

endpackage

// File: rtl/tmr_pick3.sv
module tmr_pick3 #(
  parameter int unsigned W   = 16,
  parameter int unsigned NUM = 3
) (
  input  logic [NUM*W-1:0] cand_i,
  output logic [W-1:0]     max_o
);

  generate
    if (NUM == 1) begin : g_single
      assign max_o = cand_i[W-1:0];
    end else if (NUM == 2) begin : g_pair
      logic [W-1:0] c0, c1;
      assign c0 = cand_i[0 +: W];
      assign c1 = cand_i[W +: W];
      always_comb begin
        // equal values keep the lower index
        max_o = (c0 >= c1) ? c0 : c1;
      end
    end else begin : g_triple
      logic [W-1:0] c0, c1, c2, m01;
      assign c0 = cand_i[0 +: W];
      assign c1 = cand_i[W +: W];
      assign c2 = cand_i[2*W +: W];
      always_comb begin
        m01   = (c0 >= c1) ? c0 : c1;
        max_o = (m01 >= c2) ? m01 : c2;
      end
    end
  endgenerate

endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
  import tri_max_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned N_CAND = 18,
  localparam int unsigned N_OUT = groups_of3(N_CAND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [N_CAND*W-1:0] data_i,
  output logic              valid_o,
  output logic [N_OUT*W-1:0]  data_o
);

  logic [N_OUT*W-1:0] grp_max;
  logic [N_OUT*W-1:0] data_n;
  logic               valid_n;

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_grp
      localparam int unsigned BASE = 3 * g;
      localparam int unsigned GS   = (N_CAND - BASE >= 3) ? 3 : (N_CAND - BASE);

      tmr_pick3 #(.W(W), .NUM(GS)) u_pick (
        .cand_i (data_i[BASE*W +: GS*W]),
        .max_o  (grp_max[g*W +: W])
      );

      for (genvar k = 0; k < GS; k++) begin : g_mem
        // R3
        stage_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
          valid_i |=> data_o[g*W +: W] >= $past(data_i[(BASE+k)*W +: W]));
      end
    end
  endgenerate

  // next-state: data enabled by valid, valid follows input
  always_comb begin
    valid_n = valid_i;
    data_n  = valid_i ? grp_max : data_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_n;
  end

  always_ff @(posedge clk) begin
    data_o <= data_n;
  end

  // R2
  stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(data_o));

endmodule

// File: rtl/tri_max_reduce.sv
module tri_max_reduce
  import tri_max_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_IN   = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_max
);

  localparam int unsigned C1 = groups_of3(N_IN);
  localparam int unsigned C2 = groups_of3(C1);
  localparam int unsigned C3 = groups_of3(C2);

  logic              v1, v2, v3;
  logic [C1*DATA_W-1:0] d1;
  logic [C2*DATA_W-1:0] d2;
  logic [C3*DATA_W-1:0] d3;

  tmr_stage #(.W(DATA_W), .N_CAND(N_IN)) u_st1 (
    .clk (clk), .rst_n (rst_n),
    .valid_i (in_valid), .data_i (in_data),
    .valid_o (v1), .data_o (d1)
  );

  tmr_stage #(.W(DATA_W), .N_CAND(C1)) u_st2 (
    .clk (clk), .rst_n (rst_n),
    .valid_i (v1), .data_i (d1),
    .valid_o (v2), .data_o (d2)
  );

  tmr_stage #(.W(DATA_W), .N_CAND(C2)) u_st3 (
    .clk (clk), .rst_n (rst_n),
    .valid_i (v2), .data_i (d2),
    .valid_o (v3), .data_o (d3)
  );

  assign out_valid = v3;
  assign out_max   = d3[DATA_W-1:0];

  // R2
  lat3_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R2
  lat3_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/tri_max_reduce_bench.sv
module tri_max_reduce_bench;

  localparam int W  = 4;
  localparam int N  = 18;
  localparam int NO = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [N*W-1:0] in_data;
  logic [NO*W-1:0] in_data_o;
  logic           out_valid, out_valid_o;
  logic [W-1:0]   out_max, out_max_o;

  always #4 clk = ~clk;

  tri_max_reduce #(.DATA_W(W), .N_IN(N)) u_tri_max_reduce (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_max (out_max)
  );

  tri_max_reduce #(.DATA_W(W), .N_IN(NO)) u_tri_max_reduce_odd (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data_o),
    .out_valid (out_valid_o), .out_max (out_max_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] words [N];
  bit           hv [3];
  logic [W-1:0] hm [3];
  logic [W-1:0] ho [3];
  logic [W-1:0] last_m, last_o;
  bit           have_last = 0;
  logic [15:0]  lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] maxn(input int n);
    logic [W-1:0] m = '0;
    for (int k = 0; k < n; k++) if (words[k] > m) m = words[k];
    return m;
  endfunction

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic step(input bit v, input string tag);
    @(negedge clk);
    chk(out_valid == hv[2], "R2", out_valid, hv[2]);
    chk(out_valid_o == hv[2], "R2", out_valid_o, hv[2]);
    if (hv[2]) begin
      chk(out_max == hm[2], tag, out_max, hm[2]);
      chk(out_max_o == ho[2], "R8", out_max_o, ho[2]);
      last_m = hm[2];
      last_o = ho[2];
      have_last = 1;
    end else if (have_last) begin
      chk(out_max == last_m, "R7", out_max, last_m);
      chk(out_max_o == last_o, "R7", out_max_o, last_o);
    end
    hv[2] = hv[1]; hm[2] = hm[1]; ho[2] = ho[1];
    hv[1] = hv[0]; hm[1] = hm[0]; ho[1] = ho[0];
    hv[0] = v;     hm[0] = maxn(N); ho[0] = maxn(NO);
    in_valid = v;
    for (int k = 0; k < N; k++) in_data[k*W +: W] = words[k];
    for (int k = 0; k < NO; k++) in_data_o[k*W +: W] = words[k];
  endtask

  task automatic fill_rand();
    for (int k = 0; k < N; k++) begin
      next_lfsr();
      words[k] = lfsr[W-1:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_data_o = '0;
    for (int k = 0; k < 3; k++) begin hv[k] = 0; hm[k] = '0; ho[k] = '0; end
    for (int k = 0; k < N; k++) words[k] = '0;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", out_valid, 0);
      chk(out_valid_o == 1'b0, "R1", out_valid_o, 0);
    end
    rst_n = 1'b1;
    // R1: quiet after release
    repeat (4) step(0, "R1");

    // R3 / R6: single or double top value at every pair of positions, back to back
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        for (int k = 0; k < N; k++) words[k] = W'((k*5 + a + b) % 8);
        words[a] = W'(8 + b % 8);
        if (b != a) words[b] = W'(8 + a % 8);
        step(1, "R3");
      end
    end

    // R4: top-bit crossing at each position
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) words[k] = 4'd7;
      words[p] = 4'd8;
      step(1, "R4");
      for (int k = 0; k < N; k++) words[k] = 4'd15;
      words[p] = 4'd0;
      step(1, "R4");
    end

    // R5: uniform sets and mirrored equal maxima
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < N; k++) words[k] = W'(v);
      step(1, "R5");
    end
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < N; k++) words[k] = W'(k % 6);
      words[i] = 4'd11;
      words[N-1-i] = 4'd11;
      step(1, "R5");
    end

    // R7: one set every fourth cycle, idle data changing
    for (int s = 0; s < 24; s++) begin
      fill_rand();
      step(1, "R7");
      repeat (3) begin
        fill_rand();
        step(0, "R7");
      end
    end

    // R8: maximum in the leftover slot of the 7-word copy
    for (int v = 1; v < 16; v++) begin
      for (int k = 0; k < N; k++) words[k] = W'((v + k) % v);
      words[6] = W'(v);
      step(1, "R8");
    end

    // R6: random valid pattern with random data
    for (int c = 0; c < 1500; c++) begin
      fill_rand();
      next_lfsr();
      step(lfsr[0] | lfsr[3], "R6");
    end

    repeat (4) step(0, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule